// File: doc/BRIEF.md
# Banked Per-Pin GPIO Configuration Register File

This block holds the configuration of a group of general-purpose pins and turns it into pad control signals. A byte-wide register bus reaches it, with one byte address per pin starting at a parameterised base address. Behind each pin's single address are six configuration banks. The upper bits of a written byte say whether the byte stores data into a bank or only picks the bank that later reads of that address return.

Per pin, the banks hold the following settings: a supply select with an enable flag, the direction mode with the open-drain flag and output value, a bias code, a drive strength with a tristate flag, a function select, and a polarity flag. From these the block derives output enable, output level, open-drain, tristate and inversion for each pad. It also reports each pad's input level with the pin's polarity applied.

A small bus state machine runs each access. The states are S_IDLE, S_STORE, S_SELECT and S_READ. In S_IDLE, an accepted request moves it to S_STORE (a write with bit 7 set), to S_SELECT (a write with bit 7 clear) or to S_READ (a read). Each of those action states performs its action in one cycle and always returns to S_IDLE.

Top module: `gpio_bank_regfile`

## Requirements
- R1: After reset, every bank of every pin reads 0, except bank 5, which reads 0x08 (normal polarity). Every read-bank select is 0, and bus_busy, bus_ack, pad_oe and pad_inv are all low.
- R2: A write with bit 7 set stores the low nibble into the bank given by bits 6:4, with each bank's unused bits forced to zero. The used bits are: bank 0 bits 3:0, bank 1 bits 3:0, bank 2 bits 3:1, bank 3 bits 3:2 and 0, bank 4 bits 3:1, bank 5 bit 3. A store to bank 6 or 7 changes nothing.
- R3: A write with bit 7 clear stores nothing. It latches bits 6:4 as that pin's read-bank select. A store write leaves the select unchanged.
- R4: A read returns the selected bank of the addressed pin in bits 3:0, with bits 7:4 zero. A select of bank 6 or 7 reads 0x00.
- R5: An address outside base to base+NUM_PINS-1 reads 0x00 and ignores writes. An access to one pin never changes another pin.
- R6: bus_req is taken only while bus_busy is low. In the next cycle bus_busy is high and the action takes place. After the edge that ends that cycle, bus_ack is high for one cycle, together with the read data and the updated pad outputs. A request made while bus_busy is high is ignored.
- R7: A pin is inverted when bank 5 bit 3 is clear. pad_inv shows this, the effective output is bank 1 bit 0 XOR the inversion, and pin_level is pad_in XOR the inversion.
- R8: pad_oe is asserted only when mode bit 1 is set (bank 1 bit 3, i.e. mode 2 or 3), the tristate flag (bank 3 bit 0) is clear and the drive strength (bank 3 bits 3:2) is nonzero. In push-pull, pad_out is the effective output. In open-drain (bank 1 bit 1), the pad is enabled only when the effective output is low, and pad_out is 0.
- R9: pad_od follows bank 1 bit 1 and pad_hiz follows bank 3 bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request, taken while bus_busy is low |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write byte: bit 7 store flag, bits 6:4 bank, bits 3:0 data |
| bus_busy | output | 1 | Access in progress |
| bus_ack | output | 1 | One-cycle completion pulse |
| bus_rdata | output | 8 | Read data, valid with bus_ack after a read |
| pad_in | input | NUM_PINS | Raw pad input levels |
| pad_oe | output | NUM_PINS | Pad output enable |
| pad_out | output | NUM_PINS | Pad output level |
| pad_od | output | NUM_PINS | Open-drain mode per pin |
| pad_hiz | output | NUM_PINS | Tristate flag per pin |
| pad_inv | output | NUM_PINS | Inversion active per pin |
| pin_level | output | NUM_PINS | Pad input after polarity |

## Verification
The bench builds the block with NUM_PINS set to 8 and the base at 0x150. With this setting, random addresses that stray two below the base and two beyond the last pin land outside the pin range often, so rejected writes and zero reads are exercised alongside the in-range pins. Eight pins also keep the full sweep of every bank on every pin after reset short. Random write bytes cover bank indices 6 and 7, every mode, open-drain and polarity combination, and requests issued in the busy cycle.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int NUM_BANKS = 6;
    localparam int STORE_BIT = 7;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_STORE  = 2'd1,
        S_SELECT = 2'd2,
        S_READ   = 2'd3
    } bus_state_t;

    // Bits of the low nibble that each bank keeps
    function automatic logic [3:0] bank_mask(input int idx);
        case (idx)
            0, 1:    bank_mask = 4'hF;
            2, 4:    bank_mask = 4'hE;
            3:       bank_mask = 4'hD;
            5:       bank_mask = 4'h8;
            default: bank_mask = 4'h0;
        endcase
    endfunction

endpackage

// File: rtl/gpio_bank_bus_fsm.sv
module gpio_bank_bus_fsm
    import gpio_bank_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic [7:0]        rd_value,
    output logic              busy,
    output logic              ack,
    output logic [7:0]        rdata,
    output logic              act_store,
    output logic              act_select,
    output logic [ADDR_W-1:0] lat_addr,
    output logic [6:0]        lat_data
);

    bus_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (req) begin
                    if (!we)                  state_d = S_READ;
                    else if (wdata[STORE_BIT]) state_d = S_STORE;
                    else                      state_d = S_SELECT;
                end
            end
            S_STORE:  state_d = S_IDLE;
            S_SELECT: state_d = S_IDLE;
            S_READ:   state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_addr <= '0;
            lat_data <= '0;
            ack      <= 1'b0;
            rdata    <= '0;
        end else begin
            ack <= (state_q != S_IDLE);
            if (state_q == S_IDLE && req) begin
                lat_addr <= addr;
                lat_data <= wdata[6:0];
            end
            if (state_q == S_READ) rdata <= rd_value;
        end
    end

    assign busy       = (state_q != S_IDLE);
    assign act_store  = (state_q == S_STORE);
    assign act_select = (state_q == S_SELECT);

    a_r6_action_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE) |=> (state_q == S_IDLE));

    a_r6_ack_after_action: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> $past(busy));

    a_r4_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_READ) |=> $stable(rdata));

endmodule

// File: rtl/gpio_bank_pin.sv
module gpio_bank_pin
    import gpio_bank_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       store_en,
    input  logic       select_en,
    input  logic [6:0] wdata,
    input  logic       pad_in,
    output logic [7:0] rd_byte,
    output logic       pad_oe,
    output logic       pad_out,
    output logic       pad_od,
    output logic       pad_hiz,
    output logic       pad_inv,
    output logic       pin_level
);

    logic [NUM_BANKS-1:0][3:0] bank_q;
    logic [2:0]                sel_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int b = 0; b < NUM_BANKS; b++)
                bank_q[b] <= (b == 5) ? 4'h8 : 4'h0;
        end else if (store_en) begin
            for (int b = 0; b < NUM_BANKS; b++)
                if (wdata[6:4] == 3'(b))
                    bank_q[b] <= wdata[3:0] & bank_mask(b);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         sel_q <= '0;
        else if (select_en) sel_q <= wdata[6:4];
    end

    always_comb begin
        rd_byte = '0;
        for (int b = 0; b < NUM_BANKS; b++)
            if (sel_q == 3'(b)) rd_byte[3:0] = bank_q[b];
    end

    logic       inv;
    logic       eff_out;
    logic [1:0] mode;
    logic [1:0] strength;
    logic       drive_ok;

    assign inv       = ~bank_q[5][3];
    assign eff_out   = bank_q[1][0] ^ inv;
    assign mode      = bank_q[1][3:2];
    assign strength  = bank_q[3][3:2];
    assign pad_od    = bank_q[1][1];
    assign pad_hiz   = bank_q[3][0];
    assign pad_inv   = inv;
    assign drive_ok  = mode[1] & ~pad_hiz & (strength != 2'd0);
    assign pad_oe    = drive_ok & (pad_od ? ~eff_out : 1'b1);
    assign pad_out   = pad_od ? 1'b0 : eff_out;
    assign pin_level = pad_in ^ inv;

    a_r2_no_store_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        !store_en |=> $stable(bank_q));

    a_r3_select_only_on_select: assert property (@(posedge clk) disable iff (!rst_n)
        !select_en |=> $stable(sel_q));

    a_r2_one_action: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({store_en, select_en}));

    a_r8_oe_not_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        pad_oe |-> !pad_hiz);

endmodule

// File: rtl/gpio_bank_regfile.sv
module gpio_bank_regfile
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS  = 44,
    parameter int BASE_ADDR = 'h150,
    parameter int ADDR_W    = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_req,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [7:0]          bus_wdata,
    output logic                bus_busy,
    output logic                bus_ack,
    output logic [7:0]          bus_rdata,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_od,
    output logic [NUM_PINS-1:0] pad_hiz,
    output logic [NUM_PINS-1:0] pad_inv,
    output logic [NUM_PINS-1:0] pin_level
);

    logic                     act_store;
    logic                     act_select;
    logic [ADDR_W-1:0]        lat_addr;
    logic [6:0]               lat_data;
    logic [7:0]               rd_value;
    logic [NUM_PINS-1:0]      hit;
    logic [NUM_PINS-1:0][7:0] pin_rd;

    gpio_bank_bus_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (bus_req),
        .we         (bus_we),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .rd_value   (rd_value),
        .busy       (bus_busy),
        .ack        (bus_ack),
        .rdata      (bus_rdata),
        .act_store  (act_store),
        .act_select (act_select),
        .lat_addr   (lat_addr),
        .lat_data   (lat_data)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        assign hit[p] = (lat_addr == ADDR_W'(BASE_ADDR + p));

        gpio_bank_pin u_pin (
            .clk       (clk),
            .rst_n     (rst_n),
            .store_en  (act_store & hit[p]),
            .select_en (act_select & hit[p]),
            .wdata     (lat_data),
            .pad_in    (pad_in[p]),
            .rd_byte   (pin_rd[p]),
            .pad_oe    (pad_oe[p]),
            .pad_out   (pad_out[p]),
            .pad_od    (pad_od[p]),
            .pad_hiz   (pad_hiz[p]),
            .pad_inv   (pad_inv[p]),
            .pin_level (pin_level[p])
        );
    end

    always_comb begin
        rd_value = '0;
        for (int p = 0; p < NUM_PINS; p++)
            if (hit[p]) rd_value = rd_value | pin_rd[p];
    end

    a_r5_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));

    a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |-> (bus_rdata[7:4] == 4'h0));

endmodule

// File: tb/gpio_bank_regfile_tb.sv
module gpio_bank_regfile_tb;

    localparam int N      = 8;
    localparam int BASE   = 'h150;
    localparam int ADDR_W = 9;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_req = 1'b0;
    logic              bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [7:0]        bus_wdata = '0;
    logic              bus_busy, bus_ack;
    logic [7:0]        bus_rdata;
    logic [N-1:0]      pad_in = '0;
    logic [N-1:0]      pad_oe, pad_out, pad_od, pad_hiz, pad_inv, pin_level;

    int checks = 0;
    int failures = 0;

    logic [3:0] m_bank [N][6];
    logic [2:0] m_sel  [N];

    always #10 clk = ~clk;

    gpio_bank_regfile #(.NUM_PINS(N), .BASE_ADDR(BASE), .ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_busy(bus_busy),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out), .pad_od(pad_od),
        .pad_hiz(pad_hiz), .pad_inv(pad_inv), .pin_level(pin_level)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] mask_of(input int b);
        case (b)
            0, 1:    return 4'hF;
            2, 4:    return 4'hE;
            3:       return 4'hD;
            5:       return 4'h8;
            default: return 4'h0;
        endcase
    endfunction

    function automatic bit in_range(input logic [ADDR_W-1:0] a);
        return (int'(a) >= BASE) && (int'(a) < BASE + N);
    endfunction

    function automatic logic [7:0] exp_read(input logic [ADDR_W-1:0] a);
        int p;
        if (!in_range(a)) return 8'h00;
        p = int'(a) - BASE;
        if (m_sel[p] > 3'd5) return 8'h00;
        return {4'h0, m_bank[p][m_sel[p]]};
    endfunction

    function automatic void model_write(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        int p;
        if (!in_range(a)) return;
        p = int'(a) - BASE;
        if (d[7]) begin
            if (d[6:4] < 3'd6) m_bank[p][d[6:4]] = d[3:0] & mask_of(int'(d[6:4]));
        end else begin
            m_sel[p] = d[6:4];
        end
    endfunction

    // one access: returns ack seen, busy seen in action cycle, read data
    task automatic xfer(input logic we, input logic [ADDR_W-1:0] a, input logic [7:0] d,
                        output logic ack_o, output logic busy_o, output logic [7:0] rd_o);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0;
        busy_o = bus_busy;
        @(negedge clk);
        ack_o = bus_ack;
        rd_o  = bus_rdata;
    endtask

    task automatic do_write(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        logic ak, bz; logic [7:0] r;
        xfer(1'b1, a, d, ak, bz, r);
        model_write(a, d);
    endtask

    task automatic do_read_check(input logic [ADDR_W-1:0] a, input string req);
        logic ak, bz; logic [7:0] r;
        xfer(1'b0, a, 8'h00, ak, bz, r);
        check({req, " read"}, {24'h0, r}, {24'h0, exp_read(a)});
    endtask

    task automatic check_pads(input string tag);
        logic [N-1:0] e_oe, e_out, e_od, e_hiz, e_inv, e_lvl;
        for (int p = 0; p < N; p++) begin
            logic inv, eff, drive;
            inv = ~m_bank[p][5][3];
            eff = m_bank[p][1][0] ^ inv;
            drive = m_bank[p][1][3] & ~m_bank[p][3][0] & (m_bank[p][3][3:2] != 2'd0);
            e_od[p]  = m_bank[p][1][1];
            e_hiz[p] = m_bank[p][3][0];
            e_inv[p] = inv;
            e_oe[p]  = drive & (e_od[p] ? ~eff : 1'b1);
            e_out[p] = e_od[p] ? 1'b0 : eff;
            e_lvl[p] = pad_in[p] ^ inv;
        end
        check({"R8 pad_oe ", tag},    32'(pad_oe),    32'(e_oe));
        check({"R8 pad_out ", tag},   32'(pad_out),   32'(e_out));
        check({"R9 pad_od/hiz ", tag}, 32'({pad_od, pad_hiz}), 32'({e_od, e_hiz}));
        check({"R7 inv/level ", tag}, 32'({pad_inv, pin_level}), 32'({e_inv, e_lvl}));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic ak, bz, ak2;
        logic [7:0] r;
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));
        for (int p = 0; p < N; p++) begin
            m_sel[p] = 3'd0;
            for (int b = 0; b < 6; b++) m_bank[p][b] = (b == 5) ? 4'h8 : 4'h0;
        end

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 busy/ack", {30'h0, bus_busy, bus_ack}, 32'h0);
        check("R1 pad_oe/inv", 32'({pad_oe, pad_inv}), 32'h0);
        for (int p = 0; p < N; p++) begin
            do_read_check(ADDR_W'(BASE + p), "R1 default select");
            for (int b = 0; b < 6; b++) begin
                do_write(ADDR_W'(BASE + p), {1'b0, 3'(b), 4'h0});
                do_read_check(ADDR_W'(BASE + p), "R1 bank");
            end
        end

        // R6: handshake timing
        xfer(1'b0, ADDR_W'(BASE), 8'h00, ak, bz, r);
        check("R6 busy in action cycle", 32'(bz), 32'h1);
        check("R6 ack after action", 32'(ak), 32'h1);
        @(negedge clk);
        check("R6 ack one cycle", 32'(bus_ack), 32'h0);

        // R2: masked store into bank 3 of pin 2, then read
        do_write(ADDR_W'(BASE + 2), 8'hBF);
        do_write(ADDR_W'(BASE + 2), 8'h30);
        do_read_check(ADDR_W'(BASE + 2), "R2 masked bank3");
        // R3: store keeps select (still bank 3)
        do_write(ADDR_W'(BASE + 2), 8'h9F);
        do_read_check(ADDR_W'(BASE + 2), "R3 store keeps select");
        // R2: bank 6/7 store ignored; R4: select 7 reads zero
        do_write(ADDR_W'(BASE + 2), 8'hEF);
        do_write(ADDR_W'(BASE + 2), 8'h70);
        do_read_check(ADDR_W'(BASE + 2), "R4 select bank7");
        do_write(ADDR_W'(BASE + 2), 8'h30);
        do_read_check(ADDR_W'(BASE + 2), "R2 bank6 store ignored");
        // R5: out of range
        do_write(ADDR_W'(BASE + N), 8'h9F);
        do_read_check(ADDR_W'(BASE + N), "R5 above range");
        do_write(ADDR_W'(BASE - 1), 8'h9F);
        do_read_check(ADDR_W'(BASE - 1), "R5 below range");
        check_pads("R5 after out of range");

        // R7/R8: push-pull output on pin 0, inverted
        do_write(ADDR_W'(BASE), 8'h99);  // bank1: mode2, out1
        do_write(ADDR_W'(BASE), 8'hB4);  // bank3: strength1
        pad_in = 8'h01;
        #1;
        check_pads("R8 push-pull");
        do_write(ADDR_W'(BASE), 8'hD0);  // bank5: inverted
        check_pads("R7 inverted");
        do_write(ADDR_W'(BASE), 8'h9A);  // open drain, out0 -> eff 1 -> released
        check_pads("R8 open-drain released");
        do_write(ADDR_W'(BASE), 8'hD8);  // normal polarity, eff 0 -> driven
        check_pads("R8 open-drain driven");
        do_write(ADDR_W'(BASE), 8'hB5);  // tristate
        check_pads("R9 tristate");

        // R6: request during busy cycle ignored
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = ADDR_W'(BASE + 1); bus_wdata = 8'h90;
        @(negedge clk);
        check("R6 busy", 32'(bus_busy), 32'h1);
        bus_wdata = 8'h9F; bus_addr = ADDR_W'(BASE + 3);
        @(negedge clk);
        bus_req = 1'b0;
        ak2 = bus_ack;
        check("R6 ack", 32'(ak2), 32'h1);
        model_write(ADDR_W'(BASE + 1), 8'h90);
        do_write(ADDR_W'(BASE + 3), 8'h10);
        do_read_check(ADDR_W'(BASE + 3), "R6 busy request ignored");

        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [ADDR_W-1:0] a;
            logic [7:0] d;
            a = ADDR_W'(BASE - 2 + int'($urandom_range(N + 3)));
            d = 8'($urandom);
            pad_in = N'($urandom);
            if ($urandom_range(2) == 0) do_read_check(a, "R4 R5 random");
            else do_write(a, d);
            check_pads("random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule